// File: doc/BRIEF.md
# Ternary CAM Flow Classifier

This block classifies packets by matching a search key against a small table of ternary entries. The key is one contiguous word built by concatenating chosen packet header fields. Each slot of the table holds a value word, a mask word of the same width, a valid bit and a result word such as a flow identifier. All slots compare the key against their own entry at the same time. A search reports three things: whether any slot matched, the lowest-numbered slot that matched, and a vector with one bit for every slot that matched. It also returns the result word of the winning slot, which it reads from a separate result store indexed by that slot number.

Slots are loaded one at a time through a write port addressed by slot index, like an ordinary memory. A single write sets the value, mask, valid bit and result word of one slot. A search is requested with a strobe. Its answer appears on the next clock edge, together with a response strobe. Searches may be issued on back-to-back cycles.

Two states sequence the response. `ST_IDLE` means no answer is on the outputs. `ST_RESP` means the outputs hold the answer to the request accepted on the previous edge. There are four transitions:
- `ST_IDLE` goes to `ST_RESP` when a request arrives.
- `ST_RESP` stays in `ST_RESP` when a new request arrives.
- `ST_RESP` returns to `ST_IDLE` when no request arrives.
- `ST_IDLE` stays in `ST_IDLE` when no request arrives.

Top module: `tcam_classifier`

## Requirements
- R1: A valid slot matches when, for every bit position where its mask bit is 1, the key bit equals the stored value bit. Mask bits of 0 are don't-care. A mask of all zeros matches every key.
- R2: A slot whose valid bit is 0 never matches. Reset clears the valid bit of every slot. Writing a slot with its valid input at 0 removes that slot from matching.
- R3: `rsp_hit` is 1 exactly when at least one slot matched. When it is 1, `rsp_idx` is the lowest slot index whose bit is set in the match vector.
- R4: Bit i of `rsp_match` is 1 exactly when slot i matched the key. All matching slots are reported, not only the first.
- R5: On a hit, `rsp_result` equals the result word most recently written to the winning slot.
- R6: A request accepted at a clock edge produces `rsp_valid` = 1 with its answer during the following cycle. `rsp_valid` is 0 in any cycle that follows an edge with no request. Back-to-back requests give back-to-back responses.
- R7: When a write and a search share a cycle, the search is answered from the slot contents as they were before that write.
- R8: When no slot matches, `rsp_hit` is 0, and both `rsp_idx` and `rsp_result` are 0. `rsp_match` is also all zeros in that case.
- R9: A write changes only the slot it addresses. All other slots keep their value, mask, valid bit and result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | IDX_W | Slot index to write |
| wr_value | input | KEY_W | Stored value word |
| wr_mask | input | KEY_W | Per-bit mask; 1 = compare this bit, 0 = don't care |
| wr_valid | input | 1 | Valid bit to store in the slot |
| wr_result | input | RES_W | Classification result for the slot |
| srch_req | input | 1 | Search request strobe |
| srch_key | input | KEY_W | Search key |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_hit | output | 1 | At least one slot matched |
| rsp_idx | output | IDX_W | Lowest matching slot index; 0 on a miss |
| rsp_match | output | SLOTS | One bit per matching slot |
| rsp_result | output | RES_W | Result word of the winning slot; 0 on a miss |

## Verification
The bench targets the following corner cases:
- Several slots matching at once with different masks. An encoder that picks the highest index, or reports only one bit in the vector, gives a wrong index or a wrong vector here.
- A wildcard slot with an all-zero mask, checked before and after it is invalidated. A design that ignores the valid bit keeps reporting that slot as a hit.
- A write and a search in the same cycle aimed at the winning slot. A design that forwards the new contents returns the next slot instead.
- Misses. A design that leaves stale values on the index or result outputs fails the zero check.
- Interleaved searches and idle cycles, plus a long pseudo-random run of writes and searches. A strobe that is stuck, or late by one cycle, is exposed against the scoreboard.

// File: rtl/tcam_pkg.sv
`timescale 1ns/1ps
package tcam_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

endpackage

// File: rtl/tcam_slot.sv
`timescale 1ns/1ps
module tcam_slot #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] key,
    output logic             match,
    output logic             valid_o
);

    logic [KEY_W-1:0] value_q;
    logic [KEY_W-1:0] mask_q;
    logic             valid_q;
    logic [KEY_W-1:0] diff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            mask_q  <= '0;
            valid_q <= 1'b0;
        end else if (wr_sel) begin
            value_q <= wr_value;
            mask_q  <= wr_mask;
            valid_q <= wr_valid;
        end
    end

    always_comb begin
        diff    = (key ^ value_q) & mask_q;
        match   = valid_q && (diff == '0);
        valid_o = valid_q;
    end

    // R9: an unselected slot keeps its contents
    a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> ($stable(value_q) && $stable(mask_q) && $stable(valid_q)));

    // R2: a slot that is not valid reports no match
    a_r2_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && !wr_valid) |=> !match);

endmodule

// File: rtl/tcam_first_hit.sv
`timescale 1ns/1ps
module tcam_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R3: hit flag agrees with the vector
    always_comb begin
        a_r3_hit_any: assert (hit == (|vec));
    end

endmodule

// File: rtl/tcam_result_ram.sv
`timescale 1ns/1ps
module tcam_result_ram #(
    parameter int SLOTS = 16,
    parameter int RES_W = 16,
    parameter int IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RES_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_data
);

    logic [RES_W-1:0] mem_q [SLOTS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tcam_classifier.sv
`timescale 1ns/1ps
module tcam_classifier
    import tcam_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int SLOTS = 16,
    parameter int RES_W = 16,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic [RES_W-1:0] wr_result,
    input  logic             srch_req,
    input  logic [KEY_W-1:0] srch_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [SLOTS-1:0] rsp_match,
    output logic [RES_W-1:0] rsp_result
);

    rsp_state_e state_q, state_d;

    logic [SLOTS-1:0] match_vec;
    logic [SLOTS-1:0] valid_vec;
    logic             any_hit;
    logic [IDX_W-1:0] first_idx;
    logic [RES_W-1:0] first_res;

    logic             hit_q;
    logic [IDX_W-1:0] idx_q;
    logic [SLOTS-1:0] vec_q;
    logic [RES_W-1:0] res_q;

    // parallel compare array
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));
        tcam_slot #(.KEY_W(KEY_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_sel   (sel),
            .wr_value (wr_value),
            .wr_mask  (wr_mask),
            .wr_valid (wr_valid),
            .key      (srch_key),
            .match    (match_vec[g]),
            .valid_o  (valid_vec[g])
        );
    end

    tcam_first_hit #(.N(SLOTS), .IDX_W(IDX_W)) u_first (
        .vec (match_vec),
        .hit (any_hit),
        .idx (first_idx)
    );

    tcam_result_ram #(.SLOTS(SLOTS), .RES_W(RES_W), .IDX_W(IDX_W)) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_result),
        .rd_idx  (first_idx),
        .rd_data (first_res)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = srch_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = srch_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // answer capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            idx_q <= '0;
            vec_q <= '0;
            res_q <= '0;
        end else if (srch_req) begin
            hit_q <= any_hit;
            idx_q <= any_hit ? first_idx : '0;
            vec_q <= match_vec;
            res_q <= any_hit ? first_res : '0;
        end
    end

    // outputs
    always_comb begin
        rsp_valid  = (state_q == ST_RESP);
        rsp_hit    = hit_q;
        rsp_idx    = idx_q;
        rsp_match  = vec_q;
        rsp_result = res_q;
    end

    logic [SLOTS-1:0] below_mask;
    always_comb begin
        below_mask = (SLOTS'(1) << rsp_idx) - SLOTS'(1);
    end

    a_r6_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> rsp_valid);

    a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !rsp_valid);

    a_r3_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_match[rsp_idx] && ((rsp_match & below_mask) == '0)));

    a_r8_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_result == '0 && rsp_match == '0));

    a_r2_only_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> ((rsp_match & ~$past(valid_vec)) == '0));

endmodule

// File: tb/tb_tcam_classifier.sv
`timescale 1ns/1ps
module tb_tcam_classifier;

    localparam int KW = 32;
    localparam int NS = 16;
    localparam int RW = 16;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_mask = '0;
    logic          wr_valid = 1'b0;
    logic [RW-1:0] wr_result = '0;
    logic          srch_req = 1'b0;
    logic [KW-1:0] srch_key = '0;
    logic          rsp_valid, rsp_hit;
    logic [IW-1:0] rsp_idx;
    logic [NS-1:0] rsp_match;
    logic [RW-1:0] rsp_result;

    always #10 clk = ~clk;

    tcam_classifier #(.KEY_W(KW), .SLOTS(NS), .RES_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_valid(wr_valid),
        .wr_result(wr_result), .srch_req(srch_req), .srch_key(srch_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_match(rsp_match), .rsp_result(rsp_result)
    );

    typedef struct {
        bit            req;
        bit            hit;
        int            idx;
        logic [NS-1:0] vec;
        logic [RW-1:0] res;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    logic [KW-1:0] m_val [NS];
    logic [KW-1:0] m_msk [NS];
    bit            m_vld [NS];
    logic [RW-1:0] m_res [NS];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [KW-1:0] key, input string tag);
        exp_t e;
        e.req = 1; e.hit = 0; e.idx = 0; e.vec = '0; e.res = '0; e.tag = tag;
        for (int i = 0; i < NS; i++) begin
            if (m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == '0)) e.vec[i] = 1'b1;
        end
        for (int i = NS - 1; i >= 0; i--) begin
            if (e.vec[i]) begin e.hit = 1; e.idx = i; end
        end
        if (e.hit) e.res = m_res[e.idx];
        return e;
    endfunction

    // driver: one call per clock cycle
    task automatic step(input bit dw, input int wi, input logic [KW-1:0] wv,
                        input logic [KW-1:0] wm, input bit wvl, input logic [RW-1:0] wr,
                        input bit ds, input logic [KW-1:0] key, input string tag);
        exp_t e;
        @(negedge clk);
        if (ds) e = predict(key, tag);
        else begin
            e.req = 0; e.hit = 0; e.idx = 0; e.vec = '0; e.res = '0; e.tag = tag;
        end
        q.push_back(e);
        wr_en = dw; wr_idx = IW'(wi); wr_value = wv; wr_mask = wm;
        wr_valid = wvl; wr_result = wr;
        srch_req = ds; srch_key = key;
        if (dw) begin
            m_val[wi] = wv; m_msk[wi] = wm; m_vld[wi] = wvl; m_res[wi] = wr;
        end
    endtask

    task automatic wr(input int i, input logic [KW-1:0] v, input logic [KW-1:0] m,
                      input bit vl, input logic [RW-1:0] r);
        step(1, i, v, m, vl, r, 0, '0, "R9 write");
    endtask

    task automatic sr(input logic [KW-1:0] key, input string tag);
        step(0, 0, '0, '0, 0, '0, 1, key, tag);
    endtask

    task automatic idle(input string tag);
        step(0, 0, '0, '0, 0, '0, 0, '0, tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk({e.tag, " rsp_valid"}, 32'(rsp_valid), 32'(e.req));
                if (e.req) begin
                    chk({e.tag, " hit"}, 32'(rsp_hit), 32'(e.hit));
                    chk({e.tag, " idx"}, 32'(rsp_idx), 32'(e.idx));
                    chk({e.tag, " match"}, 32'(rsp_match), 32'(e.vec));
                    chk({e.tag, " result"}, 32'(rsp_result), 32'(e.res));
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < NS; i++) begin
            m_val[i] = '0; m_msk[i] = '0; m_vld[i] = 0; m_res[i] = '0;
        end
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        #2;
        chk("R6 reset rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R2 reset hit", 32'(rsp_hit), 32'd0);

        sr(32'h0A00_0001, "R2 empty table miss R8");
        wr(3, 32'h0A00_0000, 32'hFF00_0000, 1, 16'h1111);
        wr(5, 32'h0A00_0001, 32'hFFFF_FFFF, 1, 16'h2222);
        wr(9, 32'h1234_5678, 32'h0000_0000, 1, 16'h9999);
        sr(32'h0A00_0001, "R3 R4 R5 multi hit");
        sr(32'h0B00_0000, "R1 wildcard only");
        sr(32'h0AFF_FFFF, "R1 partial mask");
        idle("R6 idle");
        wr(9, 32'h0, 32'h0, 0, 16'h0);
        sr(32'h0B00_0000, "R2 R8 invalidated miss");
        // same-cycle write and search on the winning slot
        step(1, 3, 32'h0, 32'hFFFF_FFFF, 0, 16'h0, 1, 32'h0A00_0001, "R7 old contents");
        sr(32'h0A00_0001, "R7 after write");
        wr(0, 32'h0A00_0001, 32'hFFFF_FFFF, 1, 16'hABCD);
        sr(32'h0A00_0001, "R9 R3 slot0 wins");
        wr(15, 32'h0000_0000, 32'h0000_0000, 1, 16'hFFFF);
        sr(32'h7777_7777, "R9 R5 last slot");
        sr(32'h0A00_0001, "R6 back to back");

        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 400; n++) begin
            int s;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = int'(lfsr[3:0]);
            if (lfsr[7:5] == 3'd0) begin
                wr(s, {lfsr[15:8], lfsr[23:16], 16'h0}, {8'hFF, lfsr[31:24], 16'h0},
                   lfsr[4], lfsr[27:12]);
            end else if (lfsr[7:5] == 3'd1) begin
                idle("R6 random idle");
            end else begin
                sr(m_val[s] ^ {lfsr[10:8], 29'h0}, "R1 R3 R4 R5 random");
            end
        end
        repeat (3) idle("R6 drain");
        @(negedge clk);
        srch_req = 1'b0; wr_en = 1'b0;
        while (q.size() > 0) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule